// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the bus-facing front end of a 256-byte serial memory that sits on a two-wire (I2C) bus as a slave. It runs from a fast system clock. It oversamples the bus clock and data lines and finds START and STOP conditions and clock edges. It receives bytes MSB first and accepts a device select byte whose upper four bits are a fixed type code and whose next three bits must equal three strap inputs. It also drives acknowledge bits on an open-drain data output.

Once it is selected for writing, it loads a byte address into a single rolling address counter. It then hands each further data byte, together with its target address, to a separate write sequencer through a one-cycle strobe. A STOP that ends a write is signalled to the sequencer. Reads are served from an asynchronous memory read port at the address counter. A read can start at the current address. It can also follow a dummy write, where the address is loaded and a repeated START comes before any data byte. A read stream continues while the master acknowledges and ends on a missing acknowledge. While the sequencer reports busy, the block refuses to acknowledge a device select, so the master can poll until the write completes.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) aborts any transfer in progress, and the next byte is treated as a device select, even after a rejected select with no STOP in between. A STOP (SDA rising while SCL is high) returns the block to idle.
- R2: The device select byte is received MSB first as type code 1010 in bits 7..4, then bits 3..1 compared with straps[2:0], then bit 0 as direction (1 = read, 0 = write). On a match the block asserts sda_oe during the ninth SCL pulse.
- R3: On a select mismatch the block never asserts sda_oe, raises no strobe and ignores all bus traffic until the next START.
- R4: After a write-direction select, the next byte is loaded as the address and acknowledged. Each later byte is acknowledged and produces a one-cycle wr_byte_valid carrying the current address and the byte. The address then increments and wraps from 255 to 0.
- R5: A read-direction select returns the byte at the address counter, and the counter increments after every byte sent, so a later read with no address byte continues from there.
- R6: A write-direction select, an address byte, a repeated START and a read-direction select return the byte at that address, and no wr_byte_valid is raised.
- R7: During a read, a master acknowledge (SDA low in the ninth bit time) makes the block send the next byte. A missing acknowledge makes it release SDA and ignore the bus until the next START.
- R8: A sequential read wraps from address 255 to address 0 and keeps sending.
- R9: SDA is sampled on SCL rising, and sda_oe and mem_rd_addr change only while SCL is low.
- R10: While busy is high, a matching device select is not acknowledged.
- R11: A STOP after at least one write data byte gives a one-cycle wr_stop. A STOP during a read, or after a write select with no data byte, gives none.
- R12: After reset sda_oe, wr_byte_valid and wr_stop are low and mem_rd_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Bus clock line (asynchronous) |
| sda_in | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | Pull data line low when 1 (open drain) |
| straps | input | 3 | Device select strap bits, compared with select bits 3..1 |
| mem_rd_addr | output | 8 | Read port address (address counter) |
| mem_rd_data | input | 8 | Read port data, valid in the same cycle as the address |
| busy | input | 1 | Write sequencer busy; blocks select acknowledge |
| wr_byte_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_byte_addr | output | 8 | Address of the write byte |
| wr_byte_data | output | 8 | Value of the write byte |
| wr_stop | output | 1 | One-cycle strobe for a STOP that ends a write |

## Verification
The timing assertions assume a bus that keeps each SCL low phase well above the synchronizer latency of a few system clocks. They also assume the master never tries a START or STOP while the slave holds SDA low. The bench keeps every bus quarter-phase at eight system clocks. It changes SDA only in the middle of SCL low, except for its deliberate START and STOP edges. The read port is modelled as a combinational array, so the data present when the address is shown matches the block's same-cycle read assumption.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_ADR,
    PH_WR,
    PH_RD
  } phase_t;

  localparam logic [3:0] TYPE_CODE = 4'b1010;
endpackage

// File: rtl/es_line_sync.sv
module es_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop,
  output logic sda_s
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_pipe[0] <= 1'b1;
            sda_pipe[0] <= 1'b1;
          end else begin
            scl_pipe[0] <= scl;
            sda_pipe[0] <= sda;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_pipe[g] <= 1'b1;
            sda_pipe[g] <= 1'b1;
          end else begin
            scl_pipe[g] <= scl_pipe[g-1];
            sda_pipe[g] <= sda_pipe[g-1];
          end
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/es_addr_ctr.sv
module es_addr_ctr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_val,
  input  logic          inc_en,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_d;

  always_comb begin
    addr_d = addr;
    if (load_en)     addr_d = load_val;
    else if (inc_en) addr_d = addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                addr <= '0;
    else if (load_en | inc_en) addr <= addr_d;
  end
endmodule

// File: rtl/es_proto_fsm.sv
module es_proto_fsm
  import eeprom_slave_pkg::*;
#(
  parameter int DW      = 8,
  parameter int AW      = 8,
  parameter int STRAP_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               bus_start,
  input  logic               bus_stop,
  input  logic               sda_s,
  input  logic [STRAP_W-1:0] straps,
  input  logic               busy,
  input  logic [AW-1:0]      cur_addr,
  input  logic [DW-1:0]      rd_data,
  output logic               ctr_load,
  output logic [AW-1:0]      ctr_val,
  output logic               ctr_inc,
  output logic               sda_oe,
  output logic               wr_valid,
  output logic [AW-1:0]      wr_addr,
  output logic [DW-1:0]      wr_data,
  output logic               wr_stop
);
  localparam int CW = $clog2(DW + 2);
  localparam int TW = DW - STRAP_W - 1;
  localparam logic [CW-1:0] C_BYTE = CW'(DW);
  localparam logic [CW-1:0] C_ACK  = CW'(DW + 1);
  localparam logic [CW-1:0] C_LAST = CW'(DW - 1);

  phase_t        phase_q, phase_d;
  logic [CW-1:0] bit_q, bit_d;
  logic [DW-1:0] rx_q, rx_d, tx_q, tx_d;
  logic          oe_q, oe_d, rw_q, rw_d, mack_q, mack_d, seen_q, seen_d;
  logic          wv_d, stp_d;
  logic [AW-1:0] wa_q, wa_d;
  logic [DW-1:0] wd_q, wd_d;
  logic          sel_ok;

  assign sel_ok = (rx_q[DW-1 -: TW] == TYPE_CODE[TW-1:0]) &&
                  (rx_q[STRAP_W:1] == straps) && !busy;

  always_comb begin
    phase_d  = phase_q;
    bit_d    = bit_q;
    rx_d     = rx_q;
    tx_d     = tx_q;
    oe_d     = oe_q;
    rw_d     = rw_q;
    mack_d   = mack_q;
    seen_d   = seen_q;
    wa_d     = wa_q;
    wd_d     = wd_q;
    wv_d     = 1'b0;
    stp_d    = 1'b0;
    ctr_load = 1'b0;
    ctr_inc  = 1'b0;
    ctr_val  = rx_q[AW-1:0];
    if (bus_start) begin
      phase_d = PH_DEV;
      bit_d   = '0;
      oe_d    = 1'b0;
      seen_d  = 1'b0;
    end else if (bus_stop) begin
      stp_d   = (phase_q == PH_WR) && seen_q;
      phase_d = PH_IDLE;
      oe_d    = 1'b0;
      seen_d  = 1'b0;
    end else begin
      unique case (phase_q)
        PH_DEV, PH_ADR, PH_WR: begin
          if (scl_rise && bit_q < C_BYTE) begin
            rx_d  = {rx_q[DW-2:0], sda_s};
            bit_d = bit_q + 1'b1;
          end else if (scl_fall && bit_q == C_BYTE) begin
            bit_d = C_ACK;
            if (phase_q == PH_DEV) begin
              if (sel_ok) begin
                oe_d = 1'b1;
                rw_d = rx_q[0];
              end else begin
                phase_d = PH_IDLE;
              end
            end else if (phase_q == PH_ADR) begin
              ctr_load = 1'b1;
              oe_d     = 1'b1;
            end else begin
              wv_d    = 1'b1;
              wa_d    = cur_addr;
              wd_d    = rx_q;
              ctr_inc = 1'b1;
              oe_d    = 1'b1;
              seen_d  = 1'b1;
            end
          end else if (scl_fall && bit_q == C_ACK) begin
            oe_d  = 1'b0;
            bit_d = '0;
            if (phase_q == PH_DEV) begin
              if (rw_q) begin
                phase_d = PH_RD;
                tx_d    = rd_data;
                ctr_inc = 1'b1;
                oe_d    = ~rd_data[DW-1];
              end else begin
                phase_d = PH_ADR;
              end
            end else if (phase_q == PH_ADR) begin
              phase_d = PH_WR;
            end
          end
        end
        PH_RD: begin
          if (scl_fall && bit_q < C_LAST) begin
            tx_d  = {tx_q[DW-2:0], 1'b0};
            oe_d  = ~tx_q[DW-2];
            bit_d = bit_q + 1'b1;
          end else if (scl_fall && bit_q == C_LAST) begin
            oe_d  = 1'b0;
            bit_d = C_BYTE;
          end else if (scl_rise && bit_q == C_BYTE) begin
            mack_d = ~sda_s;
            bit_d  = C_ACK;
          end else if (scl_fall && bit_q == C_ACK) begin
            bit_d = '0;
            if (mack_q) begin
              tx_d    = rd_data;
              ctr_inc = 1'b1;
              oe_d    = ~rd_data[DW-1];
            end else begin
              phase_d = PH_IDLE;
              oe_d    = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      bit_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      oe_q     <= 1'b0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      seen_q   <= 1'b0;
      wa_q     <= '0;
      wd_q     <= '0;
      wr_valid <= 1'b0;
      wr_stop  <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      bit_q    <= bit_d;
      rx_q     <= rx_d;
      tx_q     <= tx_d;
      oe_q     <= oe_d;
      rw_q     <= rw_d;
      mack_q   <= mack_d;
      seen_q   <= seen_d;
      wa_q     <= wa_d;
      wd_q     <= wd_d;
      wr_valid <= wv_d;
      wr_stop  <= stp_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_addr = wa_q;
  assign wr_data = wd_q;
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int STRAP_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl,
  input  logic               sda_in,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] straps,
  output logic [AW-1:0]      mem_rd_addr,
  input  logic [DW-1:0]      mem_rd_data,
  input  logic               busy,
  output logic               wr_byte_valid,
  output logic [AW-1:0]      wr_byte_addr,
  output logic [DW-1:0]      wr_byte_data,
  output logic               wr_stop
);
  logic scl_rise, scl_fall, bus_start, bus_stop, sda_s;
  logic ctr_load, ctr_inc;
  logic [AW-1:0] ctr_val;

  es_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .sda_s(sda_s)
  );

  es_addr_ctr #(.AW(AW)) i_ctr (
    .clk(clk), .rst_n(rst_n), .load_en(ctr_load), .load_val(ctr_val),
    .inc_en(ctr_inc), .addr(mem_rd_addr)
  );

  es_proto_fsm #(.DW(DW), .AW(AW), .STRAP_W(STRAP_W)) i_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .sda_s(sda_s),
    .straps(straps), .busy(busy), .cur_addr(mem_rd_addr),
    .rd_data(mem_rd_data), .ctr_load(ctr_load), .ctr_val(ctr_val),
    .ctr_inc(ctr_inc), .sda_oe(sda_oe), .wr_valid(wr_byte_valid),
    .wr_addr(wr_byte_addr), .wr_data(wr_byte_data), .wr_stop(wr_stop)
  );
endmodule

// File: rtl/es_checker.sv
module es_checker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl,
  input logic          sda_oe,
  input logic [AW-1:0] mem_rd_addr,
  input logic          wr_byte_valid,
  input logic          wr_stop
);
  a_r9_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl);

  a_r9_addr_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_addr != $past(mem_rd_addr)) |-> !scl);

  a_r4_wr_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte_valid |=> !wr_byte_valid);

  a_r11_stop_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stop |=> !wr_stop);

  a_r11_stop_not_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stop && wr_byte_valid));
endmodule

bind i2c_eeprom_slave es_checker #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .scl(scl), .sda_oe(sda_oe),
  .mem_rd_addr(mem_rd_addr), .wr_byte_valid(wr_byte_valid), .wr_stop(wr_stop)
);

// File: tb/test_i2c_eeprom_slave.sv
module test_i2c_eeprom_slave;
  localparam int Q = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;
  localparam int NV = 6;
  // {select byte, address, data, expected select acknowledge}
  localparam logic [24:0] VEC [NV] = '{
    {8'hAA, 8'h10, 8'h3C, 1'b1},
    {8'hA2, 8'h20, 8'h55, 1'b0},
    {8'hAA, 8'hFF, 8'h81, 1'b1},
    {8'hBA, 8'h21, 8'h66, 1'b0},
    {8'hAA, 8'h00, 8'hE7, 1'b1},
    {8'h2A, 8'h30, 8'h11, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_in, sda_oe, wr_byte_valid, wr_stop;
  logic [7:0] mem_rd_addr, mem_rd_data, wr_byte_addr, wr_byte_data;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int n_chk = 0, n_bad = 0;
  int wr_cnt = 0, stop_cnt = 0, oe_cnt = 0, r9_viol = 0;
  logic [7:0] last_a = '0, last_d = '0;
  logic prev_oe = 1'b0;

  always #2 clk = ~clk;
  assign sda_in = sda_m & ~sda_oe;
  assign mem_rd_data = mem[mem_rd_addr];

  i2c_eeprom_slave i_i2c_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl(scl_m), .sda_in(sda_in), .sda_oe(sda_oe),
    .straps(STRAP), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .busy(busy), .wr_byte_valid(wr_byte_valid), .wr_byte_addr(wr_byte_addr),
    .wr_byte_data(wr_byte_data), .wr_stop(wr_stop)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_byte_valid) begin
        wr_cnt++;
        last_a = wr_byte_addr;
        last_d = wr_byte_data;
        mem[wr_byte_addr] = wr_byte_data;
      end
      if (wr_stop) stop_cnt++;
      if (sda_oe) oe_cnt++;
      if (sda_oe != prev_oe && scl_m) r9_viol++;
      prev_oe = sda_oe;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_in; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      d[i] = sda_in; tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = ~mack; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic rand_read(input logic [7:0] a, output logic [7:0] d);
    bit k;
    bus_start();
    send_byte(DEV_W, k);
    send_byte(a, k);
    bus_start();
    send_byte(DEV_R, k);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic finish_run();
    chk(r9_viol == 0, "R9 sda_oe moved with SCL high", r9_viol, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    int w0, s0, o0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'hA5;
      exp_mem[i] = 8'(i) ^ 8'hA5;
    end
    tick(5);
    // R12 reset state
    chk(sda_oe == 1'b0, "R12 sda_oe after reset", sda_oe, 0);
    chk(mem_rd_addr == 8'h00, "R12 mem_rd_addr after reset", mem_rd_addr, 0);
    chk(!wr_byte_valid && !wr_stop, "R12 strobes after reset", {wr_byte_valid, wr_stop}, 0);
    rst_n = 1'b1;
    tick(Q);

    // vector table: write then dummy-write random read (R2 R3 R4 R6 R11)
    for (int v = 0; v < NV; v++) begin
      logic [7:0] dv, av, xv;
      bit ea;
      {dv, av, xv, ea} = VEC[v];
      w0 = wr_cnt; s0 = stop_cnt; o0 = oe_cnt;
      bus_start();
      send_byte(dv, ack);
      chk(ack == ea, "R2 select acknowledge", ack, ea);
      if (ea) begin
        send_byte(av, ack);
        chk(ack, "R4 address acknowledge", ack, 1);
        send_byte(xv, ack);
        chk(ack, "R4 data acknowledge", ack, 1);
        bus_stop();
        chk(wr_cnt == w0 + 1 && last_a == av && last_d == xv, "R4 write strobe",
            {last_a, last_d}, {av, xv});
        chk(stop_cnt == s0 + 1, "R11 stop strobe after write", stop_cnt - s0, 1);
        exp_mem[av] = xv;
        w0 = wr_cnt; s0 = stop_cnt;
        rand_read(av, d);
        chk(d == xv, "R6 random read data", d, xv);
        chk(wr_cnt == w0, "R6 no write in dummy write", wr_cnt - w0, 0);
        chk(stop_cnt == s0, "R11 no stop strobe on read", stop_cnt - s0, 0);
      end else begin
        send_byte(av, ack);
        chk(!ack, "R3 ignored after mismatch", ack, 0);
        bus_stop();
        chk(oe_cnt == o0 && wr_cnt == w0 && stop_cnt == s0, "R3 silent after mismatch",
            oe_cnt - o0, 0);
      end
    end

    // R8 R7 sequential read across the wrap
    bus_start();
    send_byte(DEV_W, ack);
    send_byte(8'hFE, ack);
    bus_start();
    send_byte(DEV_R, ack);
    chk(ack, "R2 read select acknowledge", ack, 1);
    recv_byte(1'b1, d);
    chk(d == exp_mem[8'hFE], "R7 first sequential byte", d, exp_mem[8'hFE]);
    recv_byte(1'b1, d);
    chk(d == exp_mem[8'hFF], "R7 byte after master ack", d, exp_mem[8'hFF]);
    recv_byte(1'b1, d);
    chk(d == exp_mem[8'h00], "R8 wrap to address 0", d, exp_mem[8'h00]);
    recv_byte(1'b0, d);
    chk(d == exp_mem[8'h01], "R8 continue after wrap", d, exp_mem[8'h01]);
    // R7 after no-ack the slave stays silent
    o0 = oe_cnt; s0 = stop_cnt;
    recv_byte(1'b0, d);
    chk(d == 8'hFF && oe_cnt == o0, "R7 idle after master no-ack", d, 8'hFF);
    bus_stop();
    chk(stop_cnt == s0, "R11 no stop strobe after read", stop_cnt - s0, 0);

    // R5 current-address read continues the counter
    bus_start();
    send_byte(DEV_R, ack);
    recv_byte(1'b0, d);
    bus_stop();
    chk(d == exp_mem[8'h02], "R5 current address read", d, exp_mem[8'h02]);

    // R4 multi-byte write across the wrap
    w0 = wr_cnt; s0 = stop_cnt;
    bus_start();
    send_byte(DEV_W, ack);
    send_byte(8'hFF, ack);
    send_byte(8'h12, ack);
    send_byte(8'h34, ack);
    bus_stop();
    exp_mem[8'hFF] = 8'h12;
    exp_mem[8'h00] = 8'h34;
    chk(wr_cnt == w0 + 2 && last_a == 8'h00 && last_d == 8'h34, "R4 address wraps on write",
        {last_a, last_d}, 16'h0034);
    chk(stop_cnt == s0 + 1, "R11 one stop strobe for burst", stop_cnt - s0, 1);
    rand_read(8'hFF, d);
    chk(d == 8'h12, "R4 first burst byte stored", d, 8'h12);

    // R10 busy blocks select acknowledge
    busy = 1'b1;
    bus_start();
    send_byte(DEV_W, ack);
    bus_stop();
    chk(!ack, "R10 no ack while busy", ack, 0);
    busy = 1'b0;
    s0 = stop_cnt;
    bus_start();
    send_byte(DEV_W, ack);
    chk(ack, "R10 ack once idle", ack, 1);
    send_byte(8'h40, ack);
    bus_stop();
    chk(stop_cnt == s0, "R11 no stop strobe without data", stop_cnt - s0, 0);

    // R1 repeated START after a rejected select restarts matching
    bus_start();
    send_byte(8'hA0, ack);
    chk(!ack, "R1 rejected select", ack, 0);
    bus_start();
    send_byte(DEV_R, ack);
    chk(ack, "R1 START restarts matching", ack, 1);
    recv_byte(1'b0, d);
    bus_stop();
    chk(d == exp_mem[8'h40], "R1 read after restart", d, exp_mem[8'h40]);

    finish_run();
  end
endmodule